// File: doc/BRIEF.md
# Ping-Pong Level-1 Sample Store

This block sits between a digitizer that produces one sample word per clock and a readout path that pulls words like a FIFO. It keeps two sample banks. One of them, the active bank, takes the incoming sample on every clock. The block never waits for a trigger before it writes.

When a level-1 trigger is accepted, the active bank is frozen. It then holds the most recent `WIN` samples, including the sample presented in the trigger cycle. Writing moves to the other bank. Frozen banks are drained oldest sample first through a first-word-fall-through port. `empty` shows whether triggered data is waiting. `busy` tells the trigger source that both banks hold unread events and that no further trigger can be taken.

A trigger is ignored in two cases: while `busy` is high, or while the upstream `trig_hold` is high. Triggers lost to `busy` are counted in a saturating counter.

Top module: `ppl1_store`

## Requirements
- R1: After reset, `empty` is 1, `busy` is 0 and `drop_cnt` is 0. Writing starts in bank 0 and the read side starts at bank 0.
- R2: An accepted trigger freezes the active bank. That bank then holds the `WIN` (default 64) most recent samples, ending with the sample presented in the trigger cycle. They are read out oldest first, one word per pop.
- R3: An accepted trigger moves writing to the other bank. A second trigger, issued at least `WIN` cycles later, captures a window made only of samples written after the first trigger.
- R4: `rd_data` is valid whenever `empty` is 0. A rising clock edge with `rd_en`=1 and `empty`=0 advances to the next word. `rd_en` while `empty` is 1 has no effect on the read position.
- R5: `empty` falls in the cycle after an accepted trigger. It rises in the cycle after the last word of the last unread event is popped.
- R6: `busy` is 1 exactly while both banks hold unread events. It falls in the cycle after the last word of the older event is popped.
- R7: A trigger that arrives while `busy` is 1 is ignored. It increments the 8-bit `drop_cnt`, which saturates at 255.
- R8: A trigger that arrives while `trig_hold` is 1 is ignored. It changes neither the bank state nor `drop_cnt`.
- R9: Events are read out in the order their triggers were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_data | input | DATA_W | Sample word, written every cycle into the active bank |
| l1_trig | input | 1 | Level-1 trigger, one pulse per event |
| trig_hold | input | 1 | Upstream hold; triggers are ignored while it is 1 |
| rd_en | input | 1 | Pop the current output word |
| rd_data | output | DATA_W | Oldest unread word of the event being read |
| empty | output | 1 | No triggered data left to read |
| busy | output | 1 | Both banks hold unread events |
| drop_cnt | output | DROP_W | Saturating count of triggers lost to busy |

## Verification
The sample stream is a running cycle count, so every word read back shows which sample it was and in what order it was written. A single trigger shows where the window starts and ends and that it is read oldest first. Two widely spaced triggers show the bank swap, the read order and the `busy` timing. A trigger issued while `busy` is high shows that the frozen data stays intact, and a long burst of such triggers drives the counter to saturation. A trigger issued under `trig_hold`, and pops issued on an empty store, show that these inputs leave both the outputs and the read position unchanged.

// File: rtl/ppl1_pkg.sv
package ppl1_pkg;
   localparam int NBANK = 2;
   typedef logic [0:0] bank_t;
endpackage

// File: rtl/ppl1_bank_mem.sv
module ppl1_bank_mem
   import ppl1_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WIN    = 64,
   localparam int AW    = $clog2(WIN)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  bank_t             wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  bank_t             rd_bank,
   input  logic [AW-1:0]     rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] bank_out [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DATA_W-1:0] mem [WIN];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == bank_t'(b)))
            mem[wr_addr] <= wr_data;
      end
      assign bank_out[b] = mem[rd_addr];
   end

   assign rd_data = bank_out[rd_bank];
endmodule

// File: rtl/ppl1_ctrl.sv
module ppl1_ctrl
   import ppl1_pkg::*;
#(
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l1_trig,
   input  logic              trig_hold,
   input  logic              pop_last,
   input  bank_t             rd_bank,
   output logic [NBANK-1:0]  full_q,
   output bank_t             wr_bank,
   output logic              accept,
   output logic              busy,
   output logic [DROP_W-1:0] drop_cnt
);
   logic [NBANK-1:0] full_d;
   logic             trig_live;

   assign trig_live = l1_trig && !trig_hold;
   assign busy      = &full_q;
   assign accept    = trig_live && !full_q[wr_bank];

   always_comb begin
      full_d = full_q;
      if (pop_last) full_d[rd_bank] = 1'b0;
      if (accept)   full_d[wr_bank] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q   <= '0;
         wr_bank  <= '0;
         drop_cnt <= '0;
      end else begin
         full_q <= full_d;
         if (accept) wr_bank <= ~wr_bank;
         if (trig_live && busy && (drop_cnt != '1))
            drop_cnt <= drop_cnt + 1'b1;
      end
   end

   AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt == '1) |=> (drop_cnt == '1)); // R7
   AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drop_cnt) |-> $past(l1_trig && !trig_hold && busy)); // R7
   AST_HOLD_KEEPS_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_hold && !pop_last) |=> $stable(full_q)); // R8
endmodule

// File: rtl/ppl1_writer.sv
module ppl1_writer
   import ppl1_pkg::*;
#(
   parameter int WIN = 64,
   localparam int AW = $clog2(WIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] full_q,
   input  bank_t            wr_bank,
   input  logic             accept,
   output logic             wr_en,
   output logic [AW-1:0]    wr_ptr,
   output logic [AW-1:0]    start_q [NBANK]
);
   assign wr_en = !full_q[wr_bank];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         for (int b = 0; b < NBANK; b++) start_q[b] <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (accept) start_q[wr_bank] <= wr_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/ppl1_reader.sv
module ppl1_reader
   import ppl1_pkg::*;
#(
   parameter int WIN = 64,
   localparam int AW = $clog2(WIN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [NBANK-1:0] full_q,
   input  logic [AW-1:0]    start_q [NBANK],
   output bank_t            rd_bank,
   output logic [AW-1:0]    rd_addr,
   output logic             empty,
   output logic             pop_last
);
   logic [AW-1:0] rd_cnt;
   logic          pop;

   assign empty    = !full_q[rd_bank];
   assign pop      = rd_en && !empty;
   assign pop_last = pop && (rd_cnt == AW'(WIN - 1));
   assign rd_addr  = start_q[rd_bank] + rd_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_bank <= '0;
         rd_cnt  <= '0;
      end else if (pop) begin
         rd_cnt <= rd_cnt + 1'b1;
         if (pop_last) rd_bank <= ~rd_bank;
      end
   end

   AST_IDLE_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> $stable(rd_cnt)); // R4
endmodule

// File: rtl/ppl1_store.sv
module ppl1_store
   import ppl1_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int WIN    = 64,
   parameter int DROP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              l1_trig,
   input  logic              trig_hold,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              busy,
   output logic [DROP_W-1:0] drop_cnt
);
   localparam int AW = $clog2(WIN);

   if (DATA_W < 1 || DATA_W > 16) begin : g_bad_width
      $error("DATA_W must lie in 1..16");
   end
   if (WIN < 2 || (1 << AW) != WIN) begin : g_bad_win
      $error("WIN must be a power of two, at least 2");
   end
   if (DROP_W < 1) begin : g_bad_drop
      $error("DROP_W must be at least 1");
   end

   logic [NBANK-1:0] full_q;
   bank_t            wr_bank, rd_bank;
   logic             accept, wr_en, pop_last;
   logic [AW-1:0]    wr_ptr, rd_addr;
   logic [AW-1:0]    start_q [NBANK];

   ppl1_ctrl #(.DROP_W(DROP_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .l1_trig(l1_trig), .trig_hold(trig_hold),
      .pop_last(pop_last), .rd_bank(rd_bank), .full_q(full_q),
      .wr_bank(wr_bank), .accept(accept), .busy(busy), .drop_cnt(drop_cnt)
   );

   ppl1_writer #(.WIN(WIN)) u_writer (
      .clk(clk), .rst_n(rst_n), .full_q(full_q), .wr_bank(wr_bank),
      .accept(accept), .wr_en(wr_en), .wr_ptr(wr_ptr), .start_q(start_q)
   );

   ppl1_reader #(.WIN(WIN)) u_reader (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .full_q(full_q),
      .start_q(start_q), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .empty(empty), .pop_last(pop_last)
   );

   ppl1_bank_mem #(.DATA_W(DATA_W), .WIN(WIN)) u_mem (
      .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_ptr),
      .wr_data(smp_data), .rd_bank(rd_bank), .rd_addr(rd_addr),
      .rd_data(rd_data)
   );

   AST_BUSY_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !empty); // R6
   AST_EMPTY_FALL_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(empty) |-> $past(l1_trig && !trig_hold)); // R5
   AST_BUSY_RISE_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(l1_trig && !trig_hold && !empty)); // R6
endmodule

// File: tb/ppl1_store_tb.sv
module ppl1_store_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW  = 16;
   localparam int WIN = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] cyc = '0;
   logic          l1_trig = 1'b0, trig_hold = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          empty, busy;
   logic [7:0]    drop_cnt;
   int            total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1'b1;

   ppl1_store #(.DATA_W(DW), .WIN(WIN), .DROP_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_data(cyc), .l1_trig(l1_trig),
      .trig_hold(trig_hold), .rd_en(rd_en), .rd_data(rd_data),
      .empty(empty), .busy(busy), .drop_cnt(drop_cnt)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_trig(output logic [DW-1:0] t);
      @(negedge clk);
      t = cyc;
      l1_trig = 1'b1;
      @(negedge clk);
      l1_trig = 1'b0;
   endtask

   task automatic read_window(input logic [DW-1:0] t, input string req);
      int errs = 0;
      logic [DW-1:0] first_bad_act = '0, first_bad_exp = '0;
      for (int i = 0; i < WIN; i++) begin
         logic [DW-1:0] exp_w;
         if (i > 0) @(negedge clk);
         exp_w = t - DW'(WIN - 1) + DW'(i);
         if (empty || rd_data !== exp_w) begin
            if (errs == 0) begin first_bad_act = rd_data; first_bad_exp = exp_w; end
            errs++;
         end
         rd_en = 1'b1;
      end
      @(negedge clk);
      rd_en = 1'b0;
      chk(errs == 0, req, first_bad_act, first_bad_exp);
   endtask

   task automatic t_reset();
      chk(empty == 1'b1, "R1 empty", empty, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(drop_cnt == 8'd0, "R1 drop_cnt", drop_cnt, 0);
   endtask

   task automatic t_single();
      logic [DW-1:0] t;
      idle(70);
      pulse_trig(t);
      chk(empty == 1'b0, "R5 empty falls after trigger", empty, 0);
      chk(busy == 1'b0, "R6 one event not busy", busy, 0);
      read_window(t, "R2 window oldest first");
      chk(empty == 1'b1, "R5 empty after last word", empty, 1);
   endtask

   task automatic t_idle_pop();
      logic [DW-1:0] t;
      @(negedge clk);
      rd_en = 1'b1;
      idle(3);
      rd_en = 1'b0;
      chk(empty == 1'b1, "R4 pop on empty", empty, 1);
      idle(70);
      pulse_trig(t);
      read_window(t, "R4 idle pops keep read position");
   endtask

   task automatic t_hold();
      logic [DW-1:0] t;
      idle(70);
      trig_hold = 1'b1;
      pulse_trig(t);
      chk(empty == 1'b1, "R8 held trigger no event", empty, 1);
      chk(drop_cnt == 8'd0, "R8 held trigger not counted", drop_cnt, 0);
      trig_hold = 1'b0;
   endtask

   task automatic t_two();
      logic [DW-1:0] t1, t2, t3;
      idle(70);
      pulse_trig(t1);
      chk(busy == 1'b0, "R6 busy low after first", busy, 0);
      idle(70);
      pulse_trig(t2);
      chk(busy == 1'b1, "R6 busy with both banks full", busy, 1);
      pulse_trig(t3);
      chk(drop_cnt == 8'd1, "R7 trigger while busy counted", drop_cnt, 1);
      chk(busy == 1'b1, "R7 busy unchanged by dropped trigger", busy, 1);
      read_window(t1, "R9 first event first, R7 window intact");
      chk(busy == 1'b0, "R6 busy falls after older event", busy, 0);
      chk(empty == 1'b0, "R5 second event pending", empty, 0);
      read_window(t2, "R3 second window after swap");
      chk(empty == 1'b1, "R5 empty after both", empty, 1);
   endtask

   task automatic t_saturate();
      logic [DW-1:0] t1, t2;
      idle(70);
      pulse_trig(t1);
      idle(70);
      pulse_trig(t2);
      @(negedge clk);
      l1_trig = 1'b1;
      idle(300);
      l1_trig = 1'b0;
      @(negedge clk);
      chk(drop_cnt == 8'd255, "R7 drop_cnt saturates", drop_cnt, 255);
      read_window(t1, "R9 saturation first event");
      read_window(t2, "R3 saturation second event");
      chk(empty == 1'b1 && busy == 1'b0, "R6 idle after drain", busy, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_idle_pop();
      t_hold();
      t_two();
      t_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule